// File: doc/BRIEF.md
# Configuration Transaction Controller

This block lets software reach a small set of board-level targets through three word registers on a simple register bus: a data word, a packed command word and a two-bit status word. Writing the command word with its launch bit set starts one transaction. The command's fields pick a target: an oscillator frequency entry, a voltage reading, a shutdown request or a reboot request. The transaction runs in the cycle after the launching write, and its outcome is left in the status word.

Oscillator entries form one table. It holds six main-board entries and a parameterised number of daughter-board entries, and each entry can be read or written. Voltage readings are fixed values: one for the main board and a parameter table for the daughter board. An address that names no supported target never stalls the bus. The transaction completes with the error bit set, and the data word stays unchanged.

The bus uses valid/ready on the request and on the read response. A request is taken only when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is low while a launched transaction is still executing, and also while a read response waits for `rsp_ready`. A response stays valid, with stable data, until `rsp_ready` takes it. Writes return no response.

Top module: `cfgx_ctrl`

## Requirements
- R1: Register word 1 (command) reads back the last value written with bit 31 (launch) and bits 19:18 forced to zero. The field layout is: bit 30 write-enable, bits 29:26 controller code, bits 25:20 function, bits 17:16 site, bits 15:12 position, bits 11:0 device.
- R2: A write to word 1 with bit 31 set launches a transaction. `req_ready` is low in the cycle that follows. Afterwards status (word 2) reads 1 on success, or 3 when the target is unsupported.
- R3: A transaction whose controller code is non-zero, whose position is non-zero, or whose site is other than 0 (main) or 1 (daughter) ends with status 3.
- R4: A read transaction that fails leaves the data word (word 0) unchanged.
- R5: Function 1 read loads the oscillator entry into the data word. After reset, main-board devices 0..5 hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Daughter-board devices hold the values given by a parameter.
- R6: Function 1 write stores the data word into the entry. Main-board device 6 or above, and daughter-board device DB_OSC_N or above, end with status 3.
- R7: Function 2 read returns 3300000 for main-board device 0 and the parameter table value for daughter-board devices below DB_VOLT_N. Any other function 2 transaction, including a write, ends with status 3.
- R8: A write transaction to main-board device 0 behaves by function. Function 8 raises `shutdown_req` for exactly one cycle. Function 9 raises `reboot_req` for exactly one cycle. Functions 7 and 11 succeed with no effect. Any other target for these functions, and any read of them, ends with status 3.
- R9: A write to word 2 keeps only its low two bits, and word 2 reads with bits 31:2 zero. Word 0 is a plain 32-bit read/write register. Word 3 reads zero and ignores writes.
- R10: `req_ready` is low while a read response is pending. `rsp_valid` and `rsp_data` are held stable until `rsp_ready` is high.
- R11: After reset, the data, command and status words read 0 and both request outputs are low. The oscillator table returns to its reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word select: 0 data, 1 command, 2 status, 3 unused |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken when high with rsp_valid |
| rsp_data | output | 32 | Read response data |
| shutdown_req | output | 1 | One-cycle shutdown request pulse |
| reboot_req | output | 1 | One-cycle reboot request pulse |

## Verification
The bench builds the block with two daughter-board oscillators and two daughter-board voltage entries, each given a value that differs from every main-board constant. This makes device 2 on the daughter site the first out-of-range index for both tables. It also means a read that lands on the wrong table or entry returns a value that can be told apart. A table of bus operations covers the range limits, the routing errors and the masking rules. Directed tests then hold back the response handshake, count the request pulses, and reset mid-run after an oscillator write.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int WORD_W  = 32;
  localparam int MB_OSC_N = 6;
  localparam logic [31:0] MB_VOLT_UV = 32'd3300000;

  // command word bit layout
  localparam int B_GO   = 31;
  localparam int B_WE   = 30;
  localparam int B_CC_L = 26;
  localparam int B_FN_L = 20;
  localparam int B_ST_L = 16;
  localparam int B_PS_L = 12;

  // command bits that are stored (launch and bits 19:18 are not)
  localparam logic [31:0] CMD_KEEP = 32'h7FF3_FFFF;

  typedef enum logic [1:0] {
    W_DATA = 2'd0,
    W_CMD  = 2'd1,
    W_STAT = 2'd2,
    W_NONE = 2'd3
  } word_sel_e;

  typedef enum logic [2:0] {
    T_NONE,
    T_OSC,
    T_VOLT,
    T_SHUT,
    T_BOOT,
    T_NOP
  } tgt_e;

  function automatic logic [31:0] mb_osc_reset(input int idx);
    case (idx)
      0:       return 32'd50000000;
      1:       return 32'd23750000;
      default: return 32'd24000000;
    endcase
  endfunction
endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N  = 2,
  parameter int DB_VOLT_N = 2,
  localparam int OSC_N = MB_OSC_N + DB_OSC_N,
  localparam int IDX_W = $clog2(OSC_N)
) (
  input  logic             we,
  input  logic [3:0]       ccode,
  input  logic [5:0]       fn,
  input  logic [1:0]       site,
  input  logic [3:0]       pos,
  input  logic [11:0]      dev,
  output tgt_e             tgt,
  output logic             ok,
  output logic [IDX_W-1:0] osc_idx,
  output logic             on_main
);
  localparam logic [11:0] MB_LIM = 12'(MB_OSC_N);
  localparam logic [11:0] DB_LIM = 12'(DB_OSC_N);
  localparam logic [11:0] DV_LIM = 12'(DB_VOLT_N);

  logic route_ok;
  logic main_d0;

  assign route_ok = (ccode == 4'd0) && (pos == 4'd0) && (site[1] == 1'b0);
  assign on_main  = (site == 2'd0);
  assign main_d0  = on_main && (dev == 12'd0);

  always_comb begin
    tgt     = T_NONE;
    osc_idx = '0;
    if (route_ok) begin
      case (fn)
        6'd1: begin
          if (on_main && dev < MB_LIM) begin
            tgt     = T_OSC;
            osc_idx = IDX_W'(dev);
          end else if (!on_main && dev < DB_LIM) begin
            tgt     = T_OSC;
            osc_idx = IDX_W'(dev) + IDX_W'(MB_OSC_N);
          end
        end
        6'd2: begin
          if (!we && (main_d0 || (!on_main && dev < DV_LIM))) tgt = T_VOLT;
        end
        6'd7, 6'd11: if (we && main_d0) tgt = T_NOP;
        6'd8:        if (we && main_d0) tgt = T_SHUT;
        6'd9:        if (we && main_d0) tgt = T_BOOT;
        default:     tgt = T_NONE;
      endcase
    end
  end

  assign ok = (tgt != T_NONE);
endmodule

// File: rtl/cfgx_osc_bank.sv
module cfgx_osc_bank
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N = 2,
  parameter logic [DB_OSC_N*32-1:0] DB_OSC_RST = {DB_OSC_N{32'd25000000}},
  localparam int OSC_N = MB_OSC_N + DB_OSC_N,
  localparam int IDX_W = $clog2(OSC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wr_val,
  output logic [31:0]      rd_val
);
  logic [31:0] ent [OSC_N];

  for (genvar i = 0; i < OSC_N; i++) begin : g_ent
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic [31:0] rst_val;
    if (i < MB_OSC_N) begin : g_mb
      assign rst_val = mb_osc_reset(i);
    end else begin : g_db
      assign rst_val = DB_OSC_RST[(i-MB_OSC_N)*32 +: 32];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ent[i] <= rst_val;
      else if (wr_en && idx == MY_IDX)  ent[i] <= wr_val;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < OSC_N; k++) begin
      if (idx == IDX_W'(k)) rd_val = ent[k];
    end
  end
endmodule

// File: rtl/cfgx_volt_rom.sv
module cfgx_volt_rom
  import cfgx_pkg::*;
#(
  parameter int DB_VOLT_N = 2,
  parameter logic [DB_VOLT_N*32-1:0] DB_VOLT_TBL = {DB_VOLT_N{32'd1000000}}
) (
  input  logic        on_main,
  input  logic [11:0] dev,
  output logic [31:0] uv
);
  always_comb begin
    uv = '0;
    if (on_main) begin
      uv = MB_VOLT_UV;
    end else begin
      for (int k = 0; k < DB_VOLT_N; k++) begin
        if (dev == 12'(k)) uv = DB_VOLT_TBL[k*32 +: 32];
      end
    end
  end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N  = 2,
  parameter int DB_VOLT_N = 2,
  parameter logic [DB_OSC_N*32-1:0]  DB_OSC_RST  = {32'd33333333, 32'd25000000},
  parameter logic [DB_VOLT_N*32-1:0] DB_VOLT_TBL = {32'd1200000, 32'd900000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  output logic        shutdown_req,
  output logic        reboot_req
);
  localparam int OSC_N = MB_OSC_N + DB_OSC_N;
  localparam int IDX_W = $clog2(OSC_N);

  logic [31:0] data_q, cmd_q, rsp_q;
  logic [1:0]  stat_q;
  logic        pend_q, rspv_q, shut_q, boot_q;

  logic             accept, launch, ok;
  tgt_e             tgt;
  logic [IDX_W-1:0] osc_idx;
  logic             on_main;
  logic [31:0]      osc_rd, volt_rd, rd_mux;
  logic             osc_wr;
  word_sel_e        sel;

  assign req_ready = !pend_q && !rspv_q;
  assign accept    = req_valid && req_ready;
  assign sel       = word_sel_e'(req_addr);
  assign launch    = accept && req_write && sel == W_CMD && req_wdata[B_GO];

  cfgx_decode #(.DB_OSC_N(DB_OSC_N), .DB_VOLT_N(DB_VOLT_N)) u_dec (
    .we      (cmd_q[B_WE]),
    .ccode   (cmd_q[B_CC_L +: 4]),
    .fn      (cmd_q[B_FN_L +: 6]),
    .site    (cmd_q[B_ST_L +: 2]),
    .pos     (cmd_q[B_PS_L +: 4]),
    .dev     (cmd_q[11:0]),
    .tgt     (tgt),
    .ok      (ok),
    .osc_idx (osc_idx),
    .on_main (on_main)
  );

  assign osc_wr = pend_q && tgt == T_OSC && cmd_q[B_WE];

  cfgx_osc_bank #(.DB_OSC_N(DB_OSC_N), .DB_OSC_RST(DB_OSC_RST)) u_osc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (osc_wr),
    .idx    (osc_idx),
    .wr_val (data_q),
    .rd_val (osc_rd)
  );

  cfgx_volt_rom #(.DB_VOLT_N(DB_VOLT_N), .DB_VOLT_TBL(DB_VOLT_TBL)) u_volt (
    .on_main (on_main),
    .dev     (cmd_q[11:0]),
    .uv      (volt_rd)
  );

  // register file and transaction execution
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= '0;
      stat_q <= '0;
      pend_q <= 1'b0;
      shut_q <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      shut_q <= pend_q && tgt == T_SHUT;
      boot_q <= pend_q && tgt == T_BOOT;
      if (pend_q) begin
        pend_q <= 1'b0;
        stat_q <= {!ok, 1'b1};
        if (!cmd_q[B_WE] && tgt == T_OSC)  data_q <= osc_rd;
        if (!cmd_q[B_WE] && tgt == T_VOLT) data_q <= volt_rd;
      end else if (accept && req_write) begin
        case (sel)
          W_DATA: data_q <= req_wdata;
          W_CMD:  cmd_q  <= req_wdata & CMD_KEEP;
          W_STAT: stat_q <= req_wdata[1:0];
          default: ;
        endcase
        pend_q <= launch;
      end
    end
  end

  always_comb begin
    case (sel)
      W_DATA:  rd_mux = data_q;
      W_CMD:   rd_mux = cmd_q;
      W_STAT:  rd_mux = {30'd0, stat_q};
      default: rd_mux = '0;
    endcase
  end

  // read response channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspv_q <= 1'b0;
      rsp_q  <= '0;
    end else if (accept && !req_write) begin
      rspv_q <= 1'b1;
      rsp_q  <= rd_mux;
    end else if (rspv_q && rsp_ready) begin
      rspv_q <= 1'b0;
    end
  end

  assign rsp_valid    = rspv_q;
  assign rsp_data     = rsp_q;
  assign shutdown_req = shut_q;
  assign reboot_req   = boot_q;
endmodule

// File: rtl/cfgx_ctrl_chk.sv
module cfgx_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [1:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        shutdown_req,
  input logic        reboot_req
);
  logic take;
  assign take = rst_n && req_valid && req_ready;

  // R1: command readback never shows launch or bits 19:18
  assert_cmd_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write && req_addr == 2'd1) |=> (rsp_data[31] == 1'b0 && rsp_data[19:18] == 2'b00));

  // R2: a launch blocks the bus for the execute cycle
  assert_busy_after_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write && req_addr == 2'd1 && req_wdata[31]) |=> !req_ready);

  // R9: status reads carry only two bits
  assert_stat_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write && req_addr == 2'd2) |=> (rsp_data[31:2] == 30'd0));

  // R8: request outputs are single-cycle and exclusive
  assert_shut_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
  assert_boot_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);
  assert_req_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req));

  // R10: response is held until taken, and blocks new requests
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  assert_rsp_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind cfgx_ctrl cfgx_ctrl_chk u_chk (.*);

// File: tb/cfgx_ctrl_bench.sv
module cfgx_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GO = 32'h8000_0000;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] cw(int we, int cc, int fn, int site, int pos, int dev);
    return {1'b0, 1'(we), 4'(cc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
  endfunction
  function automatic vec_t vw(int a, logic [31:0] d, int r);
    return '{wr: 1'b1, addr: 2'(a), data: d, req: 4'(r)};
  endfunction
  function automatic vec_t vr(int a, logic [31:0] d, int r);
    return '{wr: 1'b0, addr: 2'(a), data: d, req: 4'(r)};
  endfunction

  localparam int NV = 53;
  // reads compare against data; requirement tags: R1 R2 R3 R4 R5 R6 R7 R8 R9 R11
  localparam vec_t VECS [NV] = '{
    vr(2, 0, 11), vr(0, 0, 11), vr(1, 0, 11),
    vw(1, GO | cw(0,0,1,0,0,0), 5), vr(2, 1, 2), vr(0, 32'd50000000, 5),
    vw(1, GO | cw(0,0,1,0,0,1), 5), vr(0, 32'd23750000, 5),
    vw(1, GO | cw(0,0,1,0,0,5), 5), vr(0, 32'd24000000, 5),
    vw(1, GO | cw(0,0,1,1,0,1), 5), vr(0, 32'd12000000, 5),
    vw(1, 32'h401C_0005, 1), vr(1, 32'h4010_0005, 1),
    vw(0, 32'h1234_5678, 6), vw(1, GO | cw(1,0,1,0,0,2), 6), vr(2, 1, 6),
    vw(0, 0, 6), vw(1, GO | cw(0,0,1,0,0,2), 6), vr(0, 32'h1234_5678, 6),
    vw(1, GO | cw(1,0,1,0,0,6), 6), vr(2, 3, 6),
    vw(1, GO | cw(1,0,1,1,0,2), 6), vr(2, 3, 6),
    vw(1, GO | cw(0,0,2,0,0,0), 7), vr(0, 32'd3300000, 7),
    vw(1, GO | cw(0,0,2,1,0,1), 7), vr(0, 32'd1800000, 7),
    vw(0, 32'hAAAA_5555, 4), vw(1, GO | cw(0,0,2,1,0,2), 4), vr(2, 3, 4), vr(0, 32'hAAAA_5555, 4),
    vw(1, GO | cw(1,0,2,0,0,0), 7), vr(2, 3, 7),
    vw(1, GO | cw(0,1,1,0,0,0), 3), vr(2, 3, 3),
    vw(1, GO | cw(0,0,1,0,1,0), 3), vr(2, 3, 3),
    vw(1, GO | cw(0,0,1,2,0,0), 3), vr(2, 3, 3),
    vw(2, 32'hFFFF_FFFF, 9), vr(2, 3, 9), vw(2, 0, 9), vr(2, 0, 9),
    vw(1, GO | cw(1,0,7,0,0,0), 8), vr(2, 1, 8),
    vw(1, GO | cw(1,0,11,0,0,0), 8), vr(2, 1, 8),
    vw(1, GO | cw(1,0,7,0,0,1), 8), vr(2, 3, 8),
    vw(1, GO | cw(0,0,8,0,0,0), 8), vr(2, 3, 8),
    vw(3, 32'hDEAD_BEEF, 9)
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, shutdown_req, reboot_req;
  logic [31:0] rsp_data;

  int errors = 0, checks = 0, shut_cnt = 0, boot_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_ctrl #(
    .DB_OSC_N(2), .DB_VOLT_N(2),
    .DB_OSC_RST({32'd12000000, 32'd10000000}),
    .DB_VOLT_TBL({32'd1800000, 32'd1000000})
  ) u_cfgx_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  always @(negedge clk) begin
    if (shutdown_req) shut_cnt++;
    if (reboot_req)   boot_cnt++;
  end

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [1:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = '0;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_data;
    end
  endtask

  task automatic wr_word(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus_op(1'b1, a, d, dummy);
  endtask

  task automatic rd_word(input logic [1:0] a, output logic [31:0] v);
    bus_op(1'b0, a, 32'd0, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    repeat (3) @(negedge clk);
    // R11: quiet outputs in reset
    chk(11, {30'd0, shutdown_req, reboot_req}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr_word(VECS[i].addr, VECS[i].data);
      else begin
        rd_word(VECS[i].addr, v);
        chk(int'(VECS[i].req), v, VECS[i].data);
      end
    end
    // R9: word 3 reads zero after the write to it
    rd_word(2'd3, v); chk(9, v, 32'd0);
    // R8: nothing in the table pulsed a request
    chk(8, shut_cnt, 0); chk(8, boot_cnt, 0);

    // R8: shutdown pulse
    wr_word(2'd1, GO | cw(1,0,8,0,0,0));
    repeat (4) @(negedge clk);
    chk(8, shut_cnt, 1); chk(8, boot_cnt, 0);
    rd_word(2'd2, v); chk(8, v, 32'd1);
    // R8: reboot pulse
    wr_word(2'd1, GO | cw(1,0,9,0,0,0));
    repeat (4) @(negedge clk);
    chk(8, shut_cnt, 1); chk(8, boot_cnt, 1);

    // R10: hold response back
    wr_word(2'd0, 32'hC0FF_EE01);
    rsp_ready = 1'b0;
    rd_word(2'd0, held);
    chk(10, held, 32'hC0FF_EE01);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(10, {rsp_valid, req_ready}, 32'd2);
      chk(10, rsp_data, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(10, {31'd0, rsp_valid}, 32'd0);

    // R11 and R5: reset restores registers and oscillator table
    wr_word(2'd0, 32'h0000_0055);
    wr_word(2'd1, GO | cw(1,0,1,0,0,0));
    wr_word(2'd1, GO | cw(0,0,1,0,0,0));
    rd_word(2'd0, v); chk(6, v, 32'h0000_0055);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd_word(2'd0, v); chk(11, v, 32'd0);
    rd_word(2'd1, v); chk(11, v, 32'd0);
    rd_word(2'd2, v); chk(11, v, 32'd0);
    wr_word(2'd1, GO | cw(0,0,1,0,0,0));
    rd_word(2'd0, v); chk(5, v, 32'd50000000);
    wr_word(2'd1, GO | cw(0,0,1,1,0,0));
    rd_word(2'd0, v); chk(5, v, 32'd10000000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule